// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps a small set of recently used page translations so that a requester can turn a virtual page number into a physical page number without walking the page table. Every stored translation carries the identifier of the process that owns it. A lookup therefore hits only when the page number and the process identifier both agree with a live entry. All entries are searched at the same time, and any entry may hold any page.

A lookup is offered for one cycle. In the following cycle the block reports hit or miss, and on a hit it also reports the physical page number, the access-permission bits and the dirty state. On a miss the requester fetches the translation elsewhere and writes it back through the refill port. A refill replaces an existing entry with the same page and process, or else takes the lowest free slot, or else evicts the slot named by a rotating pointer. A flush command drops the entries of one process, or of every process. A write lookup that hits marks its entry dirty. Page offsets never pass through the block.

Top module: `vpn_xlat_buf`

## Requirements
- R1: After reset every entry is empty and `rsp_valid` is 0. A lookup issued after reset misses.
- R2: A lookup whose page number and process identifier match a valid entry returns `rsp_hit`=1, together with that entry's physical page number and 3-bit permission field.
- R3: A lookup misses when no valid entry matches both the page number and the process identifier. A miss returns `rsp_ppn`=0, `rsp_perm`=0 and `rsp_dirty`=0.
- R4: `rsp_valid` is 1 in exactly the cycle after a cycle with `lk_valid`=1, and 0 otherwise. Its result fields are registered at that clock edge.
- R5: A write lookup (`lk_is_write`=1) that hits sets that entry's dirty bit, and its own response already shows `rsp_dirty`=1. A read lookup leaves the dirty bit unchanged. A refill writes the entry with its dirty bit clear.
- R6: A refill whose page number and process identifier match a valid entry overwrites that entry in place, so no duplicate appears and a later lookup returns exactly the new physical page number.
- R7: A refill with no matching entry goes into the lowest-numbered empty slot. When all slots are full it evicts the slot named by a rotating pointer. The pointer starts at slot 0 after reset and advances by one (wrapping) only on such an eviction.
- R8: A flush with `flush_all`=0 empties exactly the entries whose process identifier equals `flush_pid`. Entries of other processes keep hitting.
- R9: A flush with `flush_all`=1 empties every entry.
- R10: A lookup sees the contents as they stood before the clock edge, so a lookup in the same cycle as a flush still hits. A refill in the same cycle as a flush takes effect after the flush, so the refilled entry survives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_pid | input | 6 | Process identifier of the lookup |
| lk_is_write | input | 1 | Lookup is for a store access |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | 18 | Physical page number on a hit, else 0 |
| rsp_perm | output | 3 | Permission bits on a hit, else 0 |
| rsp_dirty | output | 1 | Dirty state of the entry after the access, else 0 |
| fill_valid | input | 1 | Refill write this cycle |
| fill_vpn | input | 20 | Virtual page number of the refill |
| fill_pid | input | 6 | Process identifier of the refill |
| fill_ppn | input | 18 | Physical page number of the refill |
| fill_perm | input | 3 | Permission bits of the refill |
| flush_valid | input | 1 | Flush command this cycle |
| flush_all | input | 1 | Flush every process instead of one |
| flush_pid | input | 6 | Process identifier to flush |

## Verification
A corrupted tag or process field shows up as a wrong hit or miss on the very next response after the lookup that touches that entry. A bad replacement pointer or free-slot search stays hidden until the buffer is full. It then surfaces one refill later, when a lookup of the entry that should have survived misses, or a lookup of the evicted entry still hits. A lost dirty update is seen on the next read hit of that page, and a duplicate entry is seen at once as a merged physical page number. Filling every slot, punching a hole with a flush, and probing neighbours on both sides of the rotating pointer bring each of these states out at the ports within a few cycles.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VPN_W  = 20;
    localparam int PPN_W  = 18;
    localparam int PID_W  = 6;
    localparam int PERM_W = 3;

    typedef struct packed {
        logic              valid;
        logic [PID_W-1:0]  pid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic              dirty;
    } xlat_entry_t;

    typedef struct packed {
        logic              hit;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic              dirty;
    } xlat_resp_t;

    function automatic logic entry_hits(input xlat_entry_t e,
                                        input logic [VPN_W-1:0] vpn,
                                        input logic [PID_W-1:0] pid);
        return e.valid && (e.vpn == vpn) && (e.pid == pid);
    endfunction

    function automatic xlat_entry_t make_entry(input logic [VPN_W-1:0] vpn,
                                               input logic [PID_W-1:0] pid,
                                               input logic [PPN_W-1:0] ppn,
                                               input logic [PERM_W-1:0] perm);
        xlat_entry_t e;
        e.valid = 1'b1;
        e.pid   = pid;
        e.vpn   = vpn;
        e.ppn   = ppn;
        e.perm  = perm;
        e.dirty = 1'b0;
        return e;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 8
) (
    input  xlat_entry_t [N-1:0] ents,
    input  logic [VPN_W-1:0]    q_vpn,
    input  logic [PID_W-1:0]    q_pid,
    output logic [N-1:0]        hit_vec
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = entry_hits(ents[i], q_vpn, q_pid);
    end

endmodule

// File: rtl/xlat_sel.sv
module xlat_sel
    import xlat_pkg::*;
#(
    parameter int N = 8
) (
    input  xlat_entry_t [N-1:0] ents,
    input  logic [N-1:0]        hit_vec,
    output xlat_resp_t          resp
);

    // AND-OR read mux: relies on at most one matching entry.
    always_comb begin
        resp = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) begin
                resp.hit   = 1'b1;
                resp.ppn   = resp.ppn  | ents[i].ppn;
                resp.perm  = resp.perm | ents[i].perm;
                resp.dirty = resp.dirty | ents[i].dirty;
            end
        end
    end

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_valid,
    input  logic [N-1:0]     valid_vec,
    input  logic [N-1:0]     dup_vec,
    output logic [IDX_W-1:0] victim
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    logic [IDX_W-1:0] rr_ptr;
    logic             need_evict;

    assign need_evict = fill_valid && !(|dup_vec) && (&valid_vec);

    always_comb begin
        victim = rr_ptr;
        if (|dup_vec) begin
            for (int i = 0; i < N; i++) begin
                if (dup_vec[i]) victim = IDX_W'(i);
            end
        end else begin
            // descending scan so the lowest empty slot is assigned last
            for (int i = N - 1; i >= 0; i--) begin
                if (!valid_vec[i]) victim = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (need_evict) begin
            rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N-1:0]        set_dirty_vec,
    input  logic                flush_valid,
    input  logic                flush_all,
    input  logic [PID_W-1:0]    flush_pid,
    input  logic                fill_valid,
    input  logic [IDX_W-1:0]    fill_idx,
    input  xlat_entry_t         fill_entry,
    output xlat_entry_t [N-1:0] ents
);

    // Update order within one edge: dirty mark, then flush, then refill.
    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (set_dirty_vec[i]) begin
                    ents[i].dirty <= 1'b1;
                end
                if (flush_valid && (flush_all || ents[i].pid == flush_pid)) begin
                    ents[i].valid <= 1'b0;
                end
            end
            if (fill_valid) begin
                ents[fill_idx] <= fill_entry;
            end
        end
    end

endmodule

// File: rtl/vpn_xlat_buf.sv
module vpn_xlat_buf
    import xlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [PID_W-1:0]  lk_pid,
    input  logic              lk_is_write,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    output logic              rsp_dirty,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PID_W-1:0]  fill_pid,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              flush_valid,
    input  logic              flush_all,
    input  logic [PID_W-1:0]  flush_pid
);

    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    xlat_entry_t [NUM_ENTRIES-1:0] ents;
    logic [NUM_ENTRIES-1:0]        lk_hit_vec;
    logic [NUM_ENTRIES-1:0]        fill_dup_vec;
    logic [NUM_ENTRIES-1:0]        valid_vec;
    logic [NUM_ENTRIES-1:0]        set_dirty_vec;
    logic [IDX_W-1:0]              fill_idx;
    xlat_resp_t                    lk_resp;
    xlat_entry_t                   fill_entry;

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_valid
        assign valid_vec[i] = ents[i].valid;
    end

    assign set_dirty_vec = (lk_valid && lk_is_write) ? lk_hit_vec : '0;
    assign fill_entry    = make_entry(fill_vpn, fill_pid, fill_ppn, fill_perm);

    xlat_match #(.N(NUM_ENTRIES)) u_lk_match (
        .ents    (ents),
        .q_vpn   (lk_vpn),
        .q_pid   (lk_pid),
        .hit_vec (lk_hit_vec)
    );

    xlat_match #(.N(NUM_ENTRIES)) u_fill_match (
        .ents    (ents),
        .q_vpn   (fill_vpn),
        .q_pid   (fill_pid),
        .hit_vec (fill_dup_vec)
    );

    xlat_sel #(.N(NUM_ENTRIES)) u_sel (
        .ents    (ents),
        .hit_vec (lk_hit_vec),
        .resp    (lk_resp)
    );

    xlat_victim #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .valid_vec  (valid_vec),
        .dup_vec    (fill_dup_vec),
        .victim     (fill_idx)
    );

    xlat_store #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk           (clk),
        .rst           (rst),
        .set_dirty_vec (set_dirty_vec),
        .flush_valid   (flush_valid),
        .flush_all     (flush_all),
        .flush_pid     (flush_pid),
        .fill_valid    (fill_valid),
        .fill_idx      (fill_idx),
        .fill_entry    (fill_entry),
        .ents          (ents)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_ppn   <= '0;
            rsp_perm  <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_resp.hit;
            rsp_ppn   <= lk_valid ? lk_resp.ppn  : '0;
            rsp_perm  <= lk_valid ? lk_resp.perm : '0;
            rsp_dirty <= lk_valid && lk_resp.hit && (lk_resp.dirty || lk_is_write);
        end
    end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk
    import xlat_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic              lk_is_write,
    input logic              rsp_valid,
    input logic              rsp_hit,
    input logic [PPN_W-1:0]  rsp_ppn,
    input logic [PERM_W-1:0] rsp_perm,
    input logic              rsp_dirty,
    input logic              fill_valid,
    input logic              flush_valid,
    input logic              flush_all,
    input logic [N-1:0]      lk_hit_vec,
    input logic [N-1:0]      valid_vec
);

    // R1
    p_reset_empty_r1: assert property (@(posedge clk)
        rst |=> (valid_vec == '0 && !rsp_valid));

    // R4
    p_rsp_follows_r4: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    // R4
    p_rsp_idle_r4: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    // R3
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0 && !rsp_dirty));

    // R6
    p_unique_match_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit_vec));

    // R5
    p_write_dirty_r5: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_is_write) |=> (!rsp_hit || rsp_dirty));

    // R9
    p_global_flush_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_valid && flush_all && !fill_valid) |=> (valid_vec == '0));

endmodule

bind vpn_xlat_buf xlat_chk #(.N(NUM_ENTRIES)) u_xlat_chk (
    .clk         (clk),
    .rst         (rst),
    .lk_valid    (lk_valid),
    .lk_is_write (lk_is_write),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_ppn     (rsp_ppn),
    .rsp_perm    (rsp_perm),
    .rsp_dirty   (rsp_dirty),
    .fill_valid  (fill_valid),
    .flush_valid (flush_valid),
    .flush_all   (flush_all),
    .lk_hit_vec  (lk_hit_vec),
    .valid_vec   (valid_vec)
);

// File: tb/tb_vpn_xlat_buf.sv
module tb_vpn_xlat_buf;
    import xlat_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              lk_valid = 1'b0;
    logic [VPN_W-1:0]  lk_vpn = '0;
    logic [PID_W-1:0]  lk_pid = '0;
    logic              lk_is_write = 1'b0;
    logic              rsp_valid, rsp_hit, rsp_dirty;
    logic [PPN_W-1:0]  rsp_ppn;
    logic [PERM_W-1:0] rsp_perm;
    logic              fill_valid = 1'b0;
    logic [VPN_W-1:0]  fill_vpn = '0;
    logic [PID_W-1:0]  fill_pid = '0;
    logic [PPN_W-1:0]  fill_ppn = '0;
    logic [PERM_W-1:0] fill_perm = '0;
    logic              flush_valid = 1'b0;
    logic              flush_all = 1'b0;
    logic [PID_W-1:0]  flush_pid = '0;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vpn_xlat_buf #(.NUM_ENTRIES(8)) dut (
        .clk(clk), .rst(rst),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_is_write(lk_is_write),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
        .rsp_perm(rsp_perm), .rsp_dirty(rsp_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pid(fill_pid),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_pid(flush_pid)
    );

    // op: 0 lookup, 1 refill, 2 flush one process, 3 flush all
    typedef struct packed {
        logic [1:0]        op;
        logic              wr;
        logic [VPN_W-1:0]  vpn;
        logic [PID_W-1:0]  pid;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
        logic              ehit;
        logic [PPN_W-1:0]  eppn;
        logic [PERM_W-1:0] eperm;
        logic              edirty;
        logic [7:0]        req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 1'b0, 20'h10, 6'd1, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd1},  // R1 miss after reset
        '{2'd1, 1'b0, 20'h10, 6'd1, 18'h0A1, 3'd5, 1'b0, 18'h0,   3'd0, 1'b0, 8'd2},
        '{2'd0, 1'b0, 20'h10, 6'd1, 18'h0,   3'd0, 1'b1, 18'h0A1, 3'd5, 1'b0, 8'd2},  // R2 hit
        '{2'd0, 1'b0, 20'h10, 6'd2, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd3},  // R3 wrong process
        '{2'd0, 1'b0, 20'h11, 6'd1, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd3},  // R3 wrong page
        '{2'd1, 1'b0, 20'h20, 6'd2, 18'h0B2, 3'd3, 1'b0, 18'h0,   3'd0, 1'b0, 8'd5},
        '{2'd0, 1'b1, 20'h20, 6'd2, 18'h0,   3'd0, 1'b1, 18'h0B2, 3'd3, 1'b1, 8'd5},  // R5 write hit
        '{2'd0, 1'b0, 20'h20, 6'd2, 18'h0,   3'd0, 1'b1, 18'h0B2, 3'd3, 1'b1, 8'd5},  // R5 sticky
        '{2'd0, 1'b0, 20'h10, 6'd1, 18'h0,   3'd0, 1'b1, 18'h0A1, 3'd5, 1'b0, 8'd5},  // R5 read keeps clean
        '{2'd1, 1'b0, 20'h10, 6'd1, 18'h154, 3'd6, 1'b0, 18'h0,   3'd0, 1'b0, 8'd6},
        '{2'd0, 1'b0, 20'h10, 6'd1, 18'h0,   3'd0, 1'b1, 18'h154, 3'd6, 1'b0, 8'd6},  // R6 overwrite
        '{2'd1, 1'b0, 20'h30, 6'd1, 18'h0C3, 3'd1, 1'b0, 18'h0,   3'd0, 1'b0, 8'd8},
        '{2'd2, 1'b0, 20'h0,  6'd1, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd8},
        '{2'd0, 1'b0, 20'h10, 6'd1, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd8},  // R8 flushed
        '{2'd0, 1'b0, 20'h30, 6'd1, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd8},  // R8 flushed
        '{2'd0, 1'b0, 20'h20, 6'd2, 18'h0,   3'd0, 1'b1, 18'h0B2, 3'd3, 1'b1, 8'd8},  // R8 other process kept
        '{2'd3, 1'b0, 20'h0,  6'd0, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd9},
        '{2'd0, 1'b0, 20'h20, 6'd2, 18'h0,   3'd0, 1'b0, 18'h0,   3'd0, 1'b0, 8'd9}   // R9 all gone
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_lookup(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p, input logic w);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_pid = p; lk_is_write = w;
        @(negedge clk);
        lk_valid = 1'b0; lk_is_write = 1'b0;
    endtask

    task automatic expect_resp(input string tag, input logic h, input logic [PPN_W-1:0] pp,
                               input logic [PERM_W-1:0] pm, input logic d);
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        check({tag, " rsp_hit"},   32'(rsp_hit),   32'(h));
        check({tag, " rsp_ppn"},   32'(rsp_ppn),   32'(pp));
        check({tag, " rsp_perm"},  32'(rsp_perm),  32'(pm));
        check({tag, " rsp_dirty"}, 32'(rsp_dirty), 32'(d));
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PID_W-1:0] p,
                           input logic [PPN_W-1:0] pp, input logic [PERM_W-1:0] pm);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_pid = p; fill_ppn = pp; fill_perm = pm;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush(input logic all, input logic [PID_W-1:0] p);
        @(negedge clk);
        flush_valid = 1'b1; flush_all = all; flush_pid = p;
        @(negedge clk);
        flush_valid = 1'b0; flush_all = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: outputs idle straight after reset
        check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check("R1 rsp_hit after reset",   32'(rsp_hit),   32'd0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                2'd0: begin
                    do_lookup(VEC[i].vpn, VEC[i].pid, VEC[i].wr);
                    expect_resp($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ehit,
                                VEC[i].eppn, VEC[i].eperm, VEC[i].edirty);
                end
                2'd1: do_fill(VEC[i].vpn, VEC[i].pid, VEC[i].ppn, VEC[i].perm);
                2'd2: do_flush(1'b0, VEC[i].pid);
                default: do_flush(1'b1, '0);
            endcase
        end

        // R4: no response in a cycle without a lookup in the one before
        @(negedge clk);
        check("R4 rsp_valid idle", 32'(rsp_valid), 32'd0);

        // R7: fresh state, fill all eight slots (slot 5 under process 4)
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            do_fill(20'h100 + 20'(i), (i == 5) ? 6'd4 : 6'd3, 18'h200 + 18'(i), 3'd1);
        end
        for (int i = 0; i < 8; i++) begin
            do_lookup(20'h100 + 20'(i), (i == 5) ? 6'd4 : 6'd3, 1'b0);
            expect_resp("R7 full set", 1'b1, 18'h200 + 18'(i), 3'd1, 1'b0);
        end
        do_fill(20'h108, 6'd3, 18'h208, 3'd1);   // evicts slot 0
        do_lookup(20'h100, 6'd3, 1'b0);
        expect_resp("R7 first eviction", 1'b0, '0, '0, 1'b0);
        do_lookup(20'h101, 6'd3, 1'b0);
        expect_resp("R7 neighbour kept", 1'b1, 18'h201, 3'd1, 1'b0);
        do_lookup(20'h108, 6'd3, 1'b0);
        expect_resp("R7 new entry", 1'b1, 18'h208, 3'd1, 1'b0);
        do_fill(20'h109, 6'd3, 18'h209, 3'd1);   // evicts slot 1
        do_lookup(20'h101, 6'd3, 1'b0);
        expect_resp("R7 pointer advanced", 1'b0, '0, '0, 1'b0);
        do_flush(1'b0, 6'd4);                      // slot 5 empty
        do_fill(20'h10A, 6'd3, 18'h20A, 3'd1);   // takes slot 5
        do_lookup(20'h102, 6'd3, 1'b0);
        expect_resp("R7 empty slot preferred", 1'b1, 18'h202, 3'd1, 1'b0);
        do_lookup(20'h10A, 6'd3, 1'b0);
        expect_resp("R7 hole filled", 1'b1, 18'h20A, 3'd1, 1'b0);
        do_fill(20'h10B, 6'd3, 18'h20B, 3'd1);   // evicts slot 2
        do_lookup(20'h102, 6'd3, 1'b0);
        expect_resp("R7 pointer held over hole fill", 1'b0, '0, '0, 1'b0);
        do_lookup(20'h103, 6'd3, 1'b0);
        expect_resp("R7 slot 3 kept", 1'b1, 18'h203, 3'd1, 1'b0);

        // R10: lookup together with a global flush sees old contents
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 20'h103; lk_pid = 6'd3;
        flush_valid = 1'b1; flush_all = 1'b1;
        @(negedge clk);
        lk_valid = 1'b0; flush_valid = 1'b0; flush_all = 1'b0;
        expect_resp("R10 lookup with flush", 1'b1, 18'h203, 3'd1, 1'b0);
        do_lookup(20'h103, 6'd3, 1'b0);
        expect_resp("R10 after flush", 1'b0, '0, '0, 1'b0);

        // R10: refill together with a global flush survives
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 20'h1F0; fill_pid = 6'd7; fill_ppn = 18'h3F0; fill_perm = 3'd7;
        flush_valid = 1'b1; flush_all = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; flush_valid = 1'b0; flush_all = 1'b0;
        do_lookup(20'h1F0, 6'd7, 1'b0);
        expect_resp("R10 refill beats flush", 1'b1, 18'h3F0, 3'd7, 1'b0);

        finish_run();
    end

endmodule